// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits beside the receive path of an Ethernet MAC and decides, while a frame arrives, whether the frame is wanted. The receive logic marks the start of each frame with a one-cycle strobe and then offers the destination address one byte per strobed cycle, most significant (first transmitted) byte first. After the sixth address byte the filter registers a verdict: accept or drop. It also raises broadcast and multicast flags for the statistics logic. The verdict and the flags stay valid until the next start-of-frame strobe.

Filtering follows a fixed priority. Promiscuous mode takes every frame. The all-ones address is taken only when broadcast reception is enabled. The reserved flow-control address is always taken, so PAUSE frames get past the multicast filter. Any other group address is checked against a 64-bit hash table, and only when multicast reception is enabled. The hash is a CRC over the address. Every individual address must match the programmed 48-bit station address exactly. The hash table and the station address are plain inputs held in registers elsewhere.

Top module: `rx_addr_filter`

## Requirements
- R1: When `cfg_promisc` is 1, `accept` is 1 for every frame, whatever the address.
- R2: An address of all ones sets `is_broadcast`, and with `cfg_promisc` at 0 it gives `accept` equal to `cfg_bcast_en`.
- R3: A group address is one whose first byte has bit 0 set and which is not all ones. It sets `is_multicast`. Unless it is the flow-control address of R5, it is dropped when `cfg_mcast_en` is 0 and `cfg_promisc` is 0.
- R4: With `cfg_mcast_en` at 1, a group address is taken only if one bit of the hash table is 1. That bit is found as follows. A CRC-32 runs over the six address bytes, first byte first and each byte least significant bit first, with reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF and no final inversion. The index is CRC bits [31:26]. Index bits [5:3] select table byte k = `hash_table[8k+7:8k]`, and index bits [2:0] select the bit inside that byte.
- R5: The flow-control address 01-80-C2-00-00-01 is always taken, whatever `cfg_mcast_en` and the hash table hold. It still sets `is_multicast`.
- R6: An individual address (first byte bit 0 clear) is taken only when all six bytes equal `station_addr`. The first byte is compared with `station_addr[47:40]` and the last with `station_addr[7:0]`.
- R7: `verdict_valid` rises on the clock edge that samples the sixth address byte, and never before. `accept`, `is_broadcast` and `is_multicast` change only on that edge. All of them hold until `frame_start`, which clears them on the next edge.
- R8: Strobed bytes after the sixth byte of a frame do not change the verdict or the flags.
- R9: Synchronous reset clears `verdict_valid`, `accept`, `is_broadcast` and `is_multicast` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | One-cycle strobe ahead of a new frame's first byte |
| byte_valid | input | 1 | Strobe qualifying `rx_byte` |
| rx_byte | input | 8 | Received byte, address bytes first |
| station_addr | input | 48 | Own individual address, first byte in [47:40] |
| hash_table | input | 64 | Eight table bytes, byte k in [8k+7:8k] |
| cfg_promisc | input | 1 | Take all frames |
| cfg_bcast_en | input | 1 | Take broadcast frames |
| cfg_mcast_en | input | 1 | Take hashed multicast frames |
| verdict_valid | output | 1 | Verdict and flags are valid |
| accept | output | 1 | Frame is to be kept |
| is_broadcast | output | 1 | Address was all ones |
| is_multicast | output | 1 | Address was a group address other than broadcast |

## Verification
The assertions assume that the configuration inputs, the station address and the hash table do not change while a frame's address is arriving. They also assume that `frame_start` never comes in the same cycle as an address byte. If either assumption is broken, a verdict could legitimately disagree with the configuration seen one cycle earlier. The bench drives every input on the falling clock edge. It changes the configuration and the table only before the start strobe, and it always leaves `byte_valid` low in the strobe cycle. The stimulus therefore stays inside what the properties take for granted.

// File: rtl/rx_af_pkg.sv
package rx_af_pkg;

    localparam int unsigned ADDR_BYTES = 6;
    localparam int unsigned HASH_IDX_W = 6;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;
    localparam logic [47:0] FLOWCTL_DA = 48'h0180C2000001;

    typedef struct packed {
        logic accept;
        logic bcast;
        logic mcast;
    } af_verdict_t;

    typedef struct packed {
        logic station_eq;
        logic all_ones;
        logic flowctl_eq;
        logic group_bit;
    } af_cmp_t;

    function automatic logic [31:0] crc32_step(input logic [31:0] crc_in,
                                               input logic [7:0] data);
        logic [31:0] c;
        c = crc_in;
        for (int b = 0; b < 8; b++) begin
            if (c[0] ^ data[b]) c = (c >> 1) ^ CRC_POLY_REFL;
            else                c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/af_crc_hash.sv
module af_crc_hash
    import rx_af_pkg::*;
#(
    parameter int unsigned IDX_W = HASH_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             take,
    input  logic [7:0]       data,
    output logic [IDX_W-1:0] hash_idx
);
    logic [31:0] crc_q;
    logic [31:0] crc_d;

    always_comb crc_d = crc32_step(crc_q, data);

    always_ff @(posedge clk) begin
        if (rst || clear)  crc_q <= CRC_SEED;
        else if (take)     crc_q <= crc_d;
    end

    // index comes from the value that includes the byte on the bus now
    assign hash_idx = crc_d[31 -: IDX_W];
endmodule

// File: rtl/af_da_compare.sv
module af_da_compare
    import rx_af_pkg::*;
#(
    parameter int unsigned NBYTES = ADDR_BYTES,
    localparam int unsigned CNT_W = $clog2(NBYTES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               take,
    input  logic [CNT_W-1:0]   pos,
    input  logic [7:0]         data,
    input  logic [8*NBYTES-1:0] station,
    input  logic [8*NBYTES-1:0] ref_addr,
    output af_cmp_t            cmp_nxt
);
    af_cmp_t cmp_q;
    logic [7:0] st_byte;
    logic [7:0] rf_byte;
    logic [CNT_W-1:0] rev;

    always_comb begin
        rev     = CNT_W'(NBYTES - 1) - pos;
        st_byte = station[{rev, 3'b000} +: 8];
        rf_byte = ref_addr[{rev, 3'b000} +: 8];
        cmp_nxt.station_eq = cmp_q.station_eq && (data == st_byte);
        cmp_nxt.all_ones   = cmp_q.all_ones && (data == 8'hFF);
        cmp_nxt.flowctl_eq = cmp_q.flowctl_eq && (data == rf_byte);
        cmp_nxt.group_bit  = (pos == '0) ? data[0] : cmp_q.group_bit;
    end

    always_ff @(posedge clk) begin
        if (rst || clear)  cmp_q <= '{station_eq: 1'b1, all_ones: 1'b1,
                                      flowctl_eq: 1'b1, group_bit: 1'b0};
        else if (take)     cmp_q <= cmp_nxt;
    end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rx_af_pkg::*;
#(
    parameter int unsigned NBYTES = ADDR_BYTES,
    parameter int unsigned IDX_W  = HASH_IDX_W,
    localparam int unsigned CNT_W = $clog2(NBYTES + 1),
    localparam int unsigned TBL_W = 1 << IDX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_start,
    input  logic                byte_valid,
    input  logic [7:0]          rx_byte,
    input  logic [8*NBYTES-1:0] station_addr,
    input  logic [TBL_W-1:0]    hash_table,
    input  logic                cfg_promisc,
    input  logic                cfg_bcast_en,
    input  logic                cfg_mcast_en,
    output logic                verdict_valid,
    output logic                accept,
    output logic                is_broadcast,
    output logic                is_multicast
);
    logic [CNT_W-1:0] pos_q;
    logic             take;
    logic             last;
    logic [IDX_W-1:0] hidx;
    logic [7:0]       tbl_byte;
    logic             hash_hit;
    af_cmp_t          cmp;
    af_verdict_t      verdict_q;
    af_verdict_t      verdict_d;
    logic             valid_q;

    assign take = byte_valid && !frame_start && (pos_q < CNT_W'(NBYTES));
    assign last = take && (pos_q == CNT_W'(NBYTES - 1));

    af_crc_hash #(.IDX_W(IDX_W)) u_hash (
        .clk(clk), .rst(rst), .clear(frame_start), .take(take),
        .data(rx_byte), .hash_idx(hidx)
    );

    af_da_compare #(.NBYTES(NBYTES)) u_cmp (
        .clk(clk), .rst(rst), .clear(frame_start), .take(take),
        .pos(pos_q), .data(rx_byte), .station(station_addr),
        .ref_addr(FLOWCTL_DA[8*NBYTES-1:0]), .cmp_nxt(cmp)
    );

    always_comb begin
        tbl_byte = hash_table[{hidx[IDX_W-1:3], 3'b000} +: 8];
        hash_hit = tbl_byte[hidx[2:0]];
        verdict_d.bcast = cmp.all_ones;
        verdict_d.mcast = cmp.group_bit && !cmp.all_ones;
        if (cfg_promisc)          verdict_d.accept = 1'b1;
        else if (cmp.all_ones)    verdict_d.accept = cfg_bcast_en;
        else if (cmp.flowctl_eq)  verdict_d.accept = 1'b1;
        else if (cmp.group_bit)   verdict_d.accept = cfg_mcast_en && hash_hit;
        else                      verdict_d.accept = cmp.station_eq;
    end

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            pos_q     <= '0;
            valid_q   <= 1'b0;
            verdict_q <= '0;
        end else begin
            if (take) pos_q <= pos_q + 1'b1;
            if (last) begin
                valid_q   <= 1'b1;
                verdict_q <= verdict_d;
            end
        end
    end

    assign verdict_valid = valid_q;
    assign accept        = verdict_q.accept;
    assign is_broadcast  = verdict_q.bcast;
    assign is_multicast  = verdict_q.mcast;
endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk (
    input logic clk,
    input logic rst,
    input logic frame_start,
    input logic cfg_promisc,
    input logic cfg_bcast_en,
    input logic verdict_valid,
    input logic accept,
    input logic is_broadcast,
    input logic is_multicast
);
    p_promisc_takes_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(verdict_valid) && $past(cfg_promisc) |-> accept);

    p_bcast_gate_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(verdict_valid) && is_broadcast && !$past(cfg_promisc)
        |-> accept == $past(cfg_bcast_en));

    p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |-> !(is_broadcast && is_multicast));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        verdict_valid && !frame_start |=> verdict_valid && $stable(accept)
        && $stable(is_broadcast) && $stable(is_multicast));

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !verdict_valid && !accept);

    p_reset_r9: assert property (@(posedge clk)
        rst |=> !verdict_valid && !accept && !is_broadcast && !is_multicast);
endmodule

bind rx_addr_filter rx_addr_filter_chk chk_i (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .cfg_promisc(cfg_promisc), .cfg_bcast_en(cfg_bcast_en),
    .verdict_valid(verdict_valid), .accept(accept),
    .is_broadcast(is_broadcast), .is_multicast(is_multicast)
);

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] STATION = 48'h021A3C4D5E6F;

    typedef struct packed {
        logic [47:0] da;
        logic        pr;
        logic        bc;
        logic        mc;
        logic [1:0]  mode;   // 0 table clear, 1 only hashed bit set, 2 all but hashed bit
        logic        ea;
        logic        eb;
        logic        em;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{48'h021A3C4D5E6F, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0},
        '{48'h021A3C4D5E6E, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},
        '{48'h061A3C4D5E6F, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0},
        '{48'hFFFFFFFFFFFF, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0},
        '{48'hFFFFFFFFFFFF, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0},
        '{48'h01005E000001, 1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1},
        '{48'h01005E000001, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1},
        '{48'h01005E000001, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1},
        '{48'h333300000002, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1},
        '{48'h0180C2000001, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1},
        '{48'hA0B0C0D0E0F0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0},
        '{48'hFFFFFFFFFFFF, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0},
        '{48'h01005E7F0102, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0;
    logic byte_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [47:0] station_addr = STATION;
    logic [63:0] hash_table = '0;
    logic cfg_promisc = 1'b0, cfg_bcast_en = 1'b0, cfg_mcast_en = 1'b0;
    logic verdict_valid, accept, is_broadcast, is_multicast;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_addr_filter dut_i (
        .clk(clk), .rst(rst), .frame_start(frame_start), .byte_valid(byte_valid),
        .rx_byte(rx_byte), .station_addr(station_addr), .hash_table(hash_table),
        .cfg_promisc(cfg_promisc), .cfg_bcast_en(cfg_bcast_en),
        .cfg_mcast_en(cfg_mcast_en), .verdict_valid(verdict_valid),
        .accept(accept), .is_broadcast(is_broadcast), .is_multicast(is_multicast)
    );

    function automatic logic [5:0] ref_index(input logic [47:0] da);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int n = 47; n >= 0; n -= 8) begin
            for (int k = 0; k < 8; k++) begin
                logic fb = c[0] ^ da[n - 7 + k];
                c = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c[31:26];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [47:0] da);
        @(negedge clk);
        frame_start = 1'b1;
        byte_valid  = 1'b0;
        @(negedge clk);
        frame_start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (i == 5) check("R7 not valid before sixth byte", 32'(verdict_valid), 32'd0);
            byte_valid = 1'b1;
            rx_byte    = da[47 - 8*i -: 8];
            @(negedge clk);
        end
        byte_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R9 reset valid", 32'(verdict_valid), 32'd0);
        check("R9 reset accept", 32'(accept), 32'd0);
        check("R9 reset flags", 32'({is_broadcast, is_multicast}), 32'd0);

        for (int v = 0; v < NV; v++) begin
            logic [5:0] hi;
            hi = ref_index(VECS[v].da);
            cfg_promisc  = VECS[v].pr;
            cfg_bcast_en = VECS[v].bc;
            cfg_mcast_en = VECS[v].mc;
            case (VECS[v].mode)
                2'd1:    hash_table = 64'd1 << hi;
                2'd2:    hash_table = ~(64'd1 << hi);
                default: hash_table = '0;
            endcase
            send_frame(VECS[v].da);
            check("R7 valid after sixth byte", 32'(verdict_valid), 32'd1);
            check("R1 R2 R3 R4 R5 R6 accept", 32'(accept), 32'(VECS[v].ea));
            check("R2 broadcast flag", 32'(is_broadcast), 32'(VECS[v].eb));
            check("R3 multicast flag", 32'(is_multicast), 32'(VECS[v].em));
        end

        // R7: verdict holds while idle, then start strobe clears it
        cfg_promisc = 1'b0; cfg_bcast_en = 1'b0; cfg_mcast_en = 1'b0;
        hash_table = '0;
        send_frame(STATION);
        repeat (4) @(negedge clk);
        check("R7 hold valid", 32'(verdict_valid), 32'd1);
        check("R7 hold accept", 32'(accept), 32'd1);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        check("R7 cleared by start", 32'(verdict_valid), 32'd0);

        // R8: trailing bytes after the address do not alter the verdict
        send_frame(48'h021A3C4D5E00);
        for (int i = 0; i < 3; i++) begin
            byte_valid = 1'b1;
            rx_byte = 8'h6F;
            @(negedge clk);
        end
        byte_valid = 1'b0;
        check("R8 accept after extra bytes", 32'(accept), 32'd0);
        check("R8 valid after extra bytes", 32'(verdict_valid), 32'd1);

        // R4: hashed bit set in a different table byte must not match
        cfg_mcast_en = 1'b1;
        hash_table = 64'd1 << (ref_index(48'h01005E000001) ^ 6'b001000);
        send_frame(48'h01005E000001);
        check("R4 wrong table byte rejects", 32'(accept), 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule